// File: doc/BRIEF.md
# CAN Error Flag and Interrupt Unit

This block sits beside a CAN protocol engine and turns its error events into software-visible state. Each engine event arrives as a one-cycle pulse on its own wire and sets a sticky flag. Flags are cleared by writing 0 to their bit: a write with every other bit at 1 clears exactly one flag. A mask register selects which flags count toward the error summary.

A second sticky register stores the detailed cause of bus errors. Its top bit chooses how new cause codes are stored. When the bit is set, new codes are merged (ORed) into the register. When it is clear, a new set of codes replaces the old contents. The unit also latches the engine's transmit and receive error counts so software can read them.

An interrupt status register holds three bits: the error summary, a receive-FIFO bit and a transmit-FIFO bit. Together with a matching enable register, it drives one interrupt line. All registers are one byte wide and sit behind a simple write port and a combinational read port.

Top module: `canerr_flag_unit`

## Requirements
- R1: A pulse on bit i of `err_evt` sets bit i of the error flag register (address 0) at the next clock edge. The bit meanings are: 7 bus lock, 6 overload frame, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive, 1 error warning, 0 bus error.
- R2: A write to address 0 clears every flag bit whose written bit is 0. Flag bits written with 1 keep their value.
- R3: When an event and a write-0 clear hit the same flag in the same cycle, the flag stays set.
- R4: The error mask register (address 1) is read/write and uses the flag bit positions. Status bit 5 (address 5) reads 1 exactly while some flag and its mask bit are both 1.
- R5: The cause store is at address 2, with bits 6 ACK delimiter, 5 dominant bit error, 4 recessive bit error, 3 CRC, 2 ACK, 1 form, 0 stuff. While bit 7 is 1, cause pulses on `code_evt` are ORed into bits 6:0.
- R6: While cause-store bit 7 is 0, any nonzero `code_evt` replaces bits 6:0 with the new codes. This holds even if a clear is written in the same cycle.
- R7: A write to address 2 clears the cause bits 6:0 that are written as 0, and loads bit 7 from the written data. Bit 7 takes effect from the next cycle.
- R8: Address 3 reads the transmit error count and address 4 reads the receive error count. Each read shows the value that was on `tec_in`/`rec_in` one clock earlier.
- R9: Pulses on `rxf_evt` and `txf_evt` set status bits 4 and 3 (address 5). These bits stay set until a write to address 5 puts 0 in them.
- R10: `irq` is 1 exactly while some status bit 5, 4 or 3 is 1 and the matching bit of the interrupt enable register (address 6, bits 5:3) is also 1.
- R11: After reset every register reads 0 and `irq` is 0.
- R12: Writes cannot change status bit 5 or the counter addresses 3 and 4. Address 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| err_evt | input | 8 | Error event pulses, one per flag bit |
| code_evt | input | 7 | Bus-error cause pulses |
| tec_in | input | 8 | Transmit error count from the engine |
| rec_in | input | 8 | Receive error count from the engine |
| rxf_evt | input | 1 | Receive FIFO interrupt event pulse |
| txf_evt | input | 1 | Transmit FIFO interrupt event pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every input changes only in step with `clk`. They also assume the event inputs carry pulses, but they never assume those pulses are rare or kept apart from register writes. The flag and counter properties are checked only once the synchronised reset has been released for one full cycle. Because of that, the reset release itself needs no assumption. The stimulus drives every input just after a rising edge and samples outputs at the falling edge. Its random phase deliberately fires events in the same cycle as clears and mode changes, so the collision cases in R3 and R6 happen many times.

// File: rtl/canerr_pkg.sv
package canerr_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int CW = 7;
  localparam logic [AW-1:0] A_FLAG = 3'd0;
  localparam logic [AW-1:0] A_MASK = 3'd1;
  localparam logic [AW-1:0] A_CODE = 3'd2;
  localparam logic [AW-1:0] A_TEC  = 3'd3;
  localparam logic [AW-1:0] A_REC  = 3'd4;
  localparam logic [AW-1:0] A_STAT = 3'd5;
  localparam logic [AW-1:0] A_IEN  = 3'd6;
  localparam int ST_ERR = 5;
  localparam int ST_RX  = 4;
  localparam int ST_TX  = 3;
endpackage

// File: rtl/canerr_rst_sync.sv
module canerr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end
  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/canerr_w0c_reg.sv
module canerr_w0c_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic [W-1:0] keep;

  always_comb begin
    keep = wr_i ? wdata_i : {W{1'b1}};
    q_d  = (q_o & keep) | set_i;   // set wins over a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/canerr_code_store.sv
module canerr_code_store #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] code_evt,
  input  logic          wr_i,
  input  logic [CW:0]   wdata_i,
  output logic          accum_o,
  output logic [CW-1:0] code_o
);
  logic [CW-1:0] code_d;
  logic [CW-1:0] keep;
  logic          accum_d;
  logic          accum_en;

  always_comb begin
    keep     = wr_i ? wdata_i[CW-1:0] : {CW{1'b1}};
    accum_en = wr_i;
    accum_d  = wdata_i[CW];
    if (accum_o)               code_d = (code_o & keep) | code_evt;
    else if (code_evt != '0)   code_d = code_evt;
    else                       code_d = code_o & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o  <= '0;
      accum_o <= 1'b0;
    end else begin
      code_o <= code_d;
      if (accum_en) accum_o <= accum_d;
    end
  end
endmodule

// File: rtl/canerr_flag_unit.sv
module canerr_flag_unit
  import canerr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] err_evt,
  input  logic [CW-1:0] code_evt,
  input  logic [DW-1:0] tec_in,
  input  logic [DW-1:0] rec_in,
  input  logic          rxf_evt,
  input  logic          txf_evt,
  output logic          irq
);
  localparam int NST = 3;

  logic          srst_n;
  logic [DW-1:0] flag_q;
  logic [DW-1:0] mask_q, mask_d;
  logic          mask_en;
  logic [CW-1:0] code_q;
  logic          accum_q;
  logic [DW-1:0] tec_q, rec_q;
  logic [1:0]    fifo_q;
  logic [NST-1:0] ien_q, ien_d;
  logic          ien_en;
  logic          summary;
  logic [NST-1:0] stat_vec;
  logic          wr_flag, wr_code, wr_stat;

  canerr_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign wr_flag = wr_en && (wr_addr == A_FLAG);
  assign wr_code = wr_en && (wr_addr == A_CODE);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  canerr_w0c_reg #(.W(DW)) u_flags (
    .clk(clk), .rst_n(srst_n), .set_i(err_evt), .wr_i(wr_flag),
    .wdata_i(wr_data), .q_o(flag_q));

  canerr_w0c_reg #(.W(2)) u_fifo (
    .clk(clk), .rst_n(srst_n), .set_i({rxf_evt, txf_evt}), .wr_i(wr_stat),
    .wdata_i({wr_data[ST_RX], wr_data[ST_TX]}), .q_o(fifo_q));

  canerr_code_store #(.CW(CW)) u_code (
    .clk(clk), .rst_n(srst_n), .code_evt(code_evt), .wr_i(wr_code),
    .wdata_i(wr_data[CW:0]), .accum_o(accum_q), .code_o(code_q));

  always_comb begin
    mask_en = wr_en && (wr_addr == A_MASK);
    mask_d  = wr_data;
    ien_en  = wr_en && (wr_addr == A_IEN);
    ien_d   = wr_data[ST_ERR:ST_TX];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mask_q <= '0;
      ien_q  <= '0;
      tec_q  <= '0;
      rec_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (ien_en)  ien_q  <= ien_d;
      tec_q <= tec_in;
      rec_q <= rec_in;
    end
  end

  always_comb begin
    summary  = |(flag_q & mask_q);
    stat_vec = {summary, fifo_q};
    irq      = |(stat_vec & ien_q);
    rd_data  = '0;
    case (rd_addr)
      A_FLAG: rd_data = flag_q;
      A_MASK: rd_data = mask_q;
      A_CODE: rd_data = {accum_q, code_q};
      A_TEC:  rd_data = tec_q;
      A_REC:  rd_data = rec_q;
      A_STAT: rd_data[ST_ERR:ST_TX] = stat_vec;
      A_IEN:  rd_data[ST_ERR:ST_TX] = ien_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/canerr_flag_unit_chk.sv
module canerr_flag_unit_chk
  import canerr_pkg::*;
(
  input logic          clk,
  input logic          srst_n,
  input logic [DW-1:0] err_evt,
  input logic [DW-1:0] flag_q,
  input logic [DW-1:0] tec_in,
  input logic [DW-1:0] tec_q,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          accum_q,
  input logic [1:0]    fifo_q,
  input logic          rxf_evt
);
  logic seen_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R1 and R3: an event always leaves its flag set
  a_r3_evt_sets_flag: assert property (@(posedge clk) disable iff (!srst_n || !seen_q)
    (err_evt != '0) |=> ((flag_q & $past(err_evt)) == $past(err_evt)));

  // R2: a flag never rises without an event
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!srst_n || !seen_q)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(err_evt)) == '0));

  // R8: transmit count follows its input by one cycle
  a_r8_tec_follows: assert property (@(posedge clk) disable iff (!srst_n || !seen_q)
    1'b1 |=> (tec_q == $past(tec_in)));

  // R7: cause-store mode only changes on a write to its address
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!srst_n || !seen_q)
    !(wr_en && wr_addr == A_CODE) |=> $stable(accum_q));

  // R9: receive-FIFO status is sticky without a status write
  a_r9_rx_sticky: assert property (@(posedge clk) disable iff (!srst_n || !seen_q)
    (fifo_q[1] && !(wr_en && wr_addr == A_STAT)) |=> fifo_q[1]);

  // R9: receive-FIFO status rises only on its event
  a_r9_rx_cause: assert property (@(posedge clk) disable iff (!srst_n || !seen_q)
    $rose(fifo_q[1]) |-> $past(rxf_evt));
endmodule

bind canerr_flag_unit canerr_flag_unit_chk u_chk (
  .clk(clk), .srst_n(srst_n), .err_evt(err_evt), .flag_q(flag_q),
  .tec_in(tec_in), .tec_q(tec_q), .wr_en(wr_en), .wr_addr(wr_addr),
  .accum_q(accum_q), .fifo_q(fifo_q), .rxf_evt(rxf_evt));

// File: tb/canerr_flag_unit_test.sv
module canerr_flag_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] err_evt = '0;
  logic [6:0] code_evt = '0;
  logic [7:0] tec_in = '0;
  logic [7:0] rec_in = '0;
  logic       rxf_evt = 1'b0;
  logic       txf_evt = 1'b0;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // reference state
  int m_flag, m_mask, m_code, m_mode, m_tec, m_rec, m_rx, m_tx, m_ien;

  canerr_flag_unit uut (.*);

  always #10 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic int m_read(int a);
    int s;
    s = (((m_flag & m_mask) != 0) ? 32 : 0) | (m_rx ? 16 : 0) | (m_tx ? 8 : 0);
    case (a)
      0: return m_flag;
      1: return m_mask;
      2: return (m_mode << 7) | m_code;
      3: return m_tec;
      4: return m_rec;
      5: return s;
      6: return m_ien;
      default: return 0;
    endcase
  endfunction

  function automatic int m_irq();
    return ((m_read(5) & m_ien) != 0) ? 1 : 0;
  endfunction

  function automatic string tag(int a);
    case (a)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R8";
      4: return "R8";
      5: return "R9";
      6: return "R10";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_mask = 0; m_code = 0; m_mode = 0;
      m_tec = 0; m_rec = 0; m_rx = 0; m_tx = 0; m_ien = 0;
    end else begin
      bit w0, w1, w2, w5, w6;
      w0 = wr_en && wr_addr == 0; w1 = wr_en && wr_addr == 1;
      w2 = wr_en && wr_addr == 2; w5 = wr_en && wr_addr == 5;
      w6 = wr_en && wr_addr == 6;
      m_flag = (w0 ? (m_flag & wr_data) : m_flag) | err_evt;
      if (w1) m_mask = wr_data;
      if (m_mode != 0) m_code = (w2 ? (m_code & wr_data[6:0]) : m_code) | code_evt;
      else if (code_evt != 0) m_code = code_evt;
      else if (w2) m_code = m_code & wr_data[6:0];
      if (w2) m_mode = wr_data[7];
      m_rx = (w5 ? (m_rx & wr_data[4]) : m_rx) | rxf_evt;
      m_tx = (w5 ? (m_tx & wr_data[3]) : m_tx) | txf_evt;
      if (w6) m_ien = wr_data & 8'h38;
      m_tec = tec_in; m_rec = rec_in;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(tag(rd_addr), rd_data, m_read(rd_addr));
      check("R10", irq, m_irq());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      report();
    end
  end

  task automatic idle_next();
    @(posedge clk); #1;
    wr_en = 0; err_evt = '0; code_evt = '0; rxf_evt = 0; txf_evt = 0;
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[7:0];
    idle_next();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R11: all registers zero after reset
    for (int a = 0; a < 8; a++) begin
      #1 rd_addr = a[2:0];
      @(negedge clk);
      check("R11", rd_data, 0);
      @(posedge clk);
    end
    @(negedge clk);
    check("R11", irq, 0);
    cmp_on = 1'b1;

    // R1: events set flags
    @(posedge clk); #1 err_evt = 8'h05; rd_addr = 0;
    idle_next(); @(negedge clk);
    check("R1", rd_data, 8'h05);
    // R2: write 0 clears one flag only
    wr(0, 8'hFE); @(negedge clk);
    check("R2", rd_data, 8'h04);
    // R3: event beats same-cycle clear
    @(posedge clk); #1 wr_en = 1; wr_addr = 0; wr_data = 8'hFB; err_evt = 8'h04;
    idle_next(); @(negedge clk);
    check("R3", rd_data, 8'h04);
    // R4 and R10: mask then enable summary interrupt
    wr(1, 8'h04); wr(6, 8'h20);
    #1 rd_addr = 5; @(negedge clk);
    check("R4", rd_data, 8'h20);
    check("R10", irq, 1);
    // R12: status bit 5 not writable
    wr(5, 8'h00); @(negedge clk);
    check("R12", rd_data, 8'h20);
    // R6: overwrite mode replaces codes
    @(posedge clk); #1 code_evt = 7'h09; rd_addr = 2;
    idle_next();
    @(posedge clk); #1 code_evt = 7'h02;
    idle_next(); @(negedge clk);
    check("R6", rd_data, 8'h02);
    // R7 and R5: set accumulate, then codes merge
    wr(2, 8'hFF); @(negedge clk);
    check("R7", rd_data, 8'h82);
    @(posedge clk); #1 code_evt = 7'h40;
    idle_next(); @(negedge clk);
    check("R5", rd_data, 8'hC2);
    // R8: counters
    @(posedge clk); #1 tec_in = 8'h7F; rd_addr = 3;
    @(negedge clk); check("R8", rd_data, 8'h00);
    @(negedge clk); check("R8", rd_data, 8'h7F);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      wr_en    = ($urandom_range(0, 3) == 0);
      wr_addr  = 3'($urandom_range(0, 7));
      wr_data  = ($urandom_range(0, 1) == 0) ? ~(8'd1 << $urandom_range(0, 7)) : 8'($urandom);
      err_evt  = ($urandom_range(0, 4) == 0) ? (8'd1 << $urandom_range(0, 7)) : 8'h00;
      code_evt = ($urandom_range(0, 4) == 0) ? 7'($urandom) : 7'h00;
      rxf_evt  = ($urandom_range(0, 9) == 0);
      txf_evt  = ($urandom_range(0, 9) == 0);
      tec_in   = 8'($urandom);
      rec_in   = 8'($urandom);
      rd_addr  = 3'($urandom_range(0, 7));
    end
    idle_next();
    @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule